// File: doc/BRIEF.md
# Time-Aware Transmit Queue Gate Scheduler

This block decides, on every clock and for each of four transmit queues, whether the frame at the head of that queue may start transmission now. It runs a repeating cycle anchored to a programmable base time. Each queue owns an open window inside the cycle, given as a start offset and an end offset in nanoseconds. The current time arrives as seconds plus nanoseconds. The block returns one transmit-eligible flag per queue. A downstream arbiter then picks among the eligible queues.

On top of plain window gating, the block has three further features. A strict mode admits a frame only if its whole wire time fits before the window end and before the cycle boundary. A per-queue launch-time mode holds the head frame until its launch stamp is reached, corrected by an offset that depends on link speed. A future-schedule control defers a base time written while no schedule runs until the clock reaches it. The position inside the cycle is tracked incrementally from the elapsed time between clocks, so no divider is needed.

Top module: `txq_gate_sched`

## Requirements
- R1: While `tsn_en` is 0, `tx_ok[q]` equals `head_vld[q]` for every queue. Windows, strict mode and launch mode have no effect. Any running or pending schedule is dropped at the next clock edge.
- R2: A queue whose `head_vld` bit is 0 never has its `tx_ok` bit set.
- R3: With `tsn_en` 1, `sched_defer` 0 and no schedule running, a write on `base_ns_wr` starts the schedule at once. The cycle position is 0 at the clock edge that samples the write. From then on the position equals the elapsed nanoseconds modulo `cycle_ns`.
- R4: While a schedule runs and `strict_en` is 0, a queue is open exactly when its window start ≤ position < its window end. A frame that would cross the window end or the cycle boundary is not blocked.
- R5: While a schedule runs and `strict_en` is 1, an open queue is eligible only when position + frame duration ≤ window end and position + frame duration ≤ `cycle_ns`.
- R6: The frame duration is (`head_len` + 20) × 8 bits multiplied by the time per bit. The time per bit is 100 ns for speed code 0 (10 Mb/s), 10 ns for code 1 (100 Mb/s), 1 ns for code 2 (1000 Mb/s) and 0.4 ns for code 3 (2500 Mb/s), with the code-3 result rounded up. Every other code is timed as 1 ns per bit.
- R7: A queue with its `launch_mode` bit set is eligible only when current time + offset ≥ its launch time. The default offsets are 600 ns for speed code 0, 200 ns for code 1, 80 ns for code 2 and 40 ns for code 3, and 0 for every other code.
- R8: With `sched_defer` 1 and no schedule running, a base write becomes pending. The schedule starts only when current time ≥ that base time, and the position there is current time − base. Until then only queues with window start 0 and window end ≥ `cycle_ns` may be eligible.
- R9: A base write while a schedule runs is held pending. The old cycle keeps running until current time ≥ the new base, then the position restarts at current time − new base.
- R10: The seconds part of the base is captured by `base_sec_wr`. It is combined with `base_ns` at the later `base_ns_wr`, and only that write arms a schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tsn_en | input | 1 | Enables gating; 0 bypasses the block |
| strict_en | input | 1 | Frame must fit in window and cycle |
| sched_defer | input | 1 | Defers a base written while idle |
| link_spd | input | 3 | Speed code: 0=10, 1=100, 2=1000, 3=2500 Mb/s |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds |
| cycle_ns | input | 30 | Cycle length in ns |
| base_sec | input | 32 | Base time seconds value |
| base_sec_wr | input | 1 | Captures `base_sec` |
| base_ns | input | 30 | Base time nanoseconds value |
| base_ns_wr | input | 1 | Commits the base time |
| win_start | input | 4×30 | Per-queue window start offsets |
| win_end | input | 4×30 | Per-queue window end offsets |
| launch_mode | input | 4 | Per-queue launch-time mode |
| head_vld | input | 4 | Per-queue head frame present |
| head_len | input | 4×14 | Per-queue head frame length in bytes |
| launch_sec | input | 4×32 | Per-queue launch time, seconds |
| launch_ns | input | 4×30 | Per-queue launch time, nanoseconds |
| tx_ok | output | 4 | Per-queue transmit-eligible flag |

## Verification
The bench builds the block with its default parameters: four queues, 14-bit lengths and the default launch offsets. Because four queues are present, gated, always-open and launch-mode queues sit side by side under one cycle. With a 4 ns time step and cycles of a few hundred to two thousand nanoseconds, every window edge and strict-fit boundary is crossed exactly, and runs span a seconds rollover. The 2500 Mb/s rounding, the unknown speed code and the exact launch-offset boundary all fall within the lengths the bench drives.

// File: rtl/tqg_pkg.sv
package tqg_pkg;

    localparam int NSW = 30;
    localparam int SECW = 32;
    localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
    localparam logic [31:0] OVERHEAD_BYTES = 32'd20;

    typedef enum logic [2:0] {
        LS_10   = 3'd0,
        LS_100  = 3'd1,
        LS_1G   = 3'd2,
        LS_2G5  = 3'd3
    } lspd_e;

    // Live schedule view handed from the phase tracker to every gate
    typedef struct packed {
        logic           live;
        logic [NSW-1:0] pos;
    } phase_t;

    // a - b in ns, assuming the two stamps lie less than a second apart
    function automatic logic [31:0] ns_gap(input logic [SECW-1:0] sa,
                                           input logic [NSW-1:0]  na,
                                           input logic [SECW-1:0] sb,
                                           input logic [NSW-1:0]  nb);
        if (sa == sb)
            return {2'b00, na} - {2'b00, nb};
        return {2'b00, na} + NS_PER_SEC - {2'b00, nb};
    endfunction

    function automatic logic time_ge(input logic [SECW-1:0] sa,
                                     input logic [NSW-1:0]  na,
                                     input logic [SECW-1:0] sb,
                                     input logic [NSW-1:0]  nb);
        return {sa, na} >= {sb, nb};
    endfunction

    // Wire time of a frame including preamble and inter-frame gap
    function automatic logic [31:0] wire_ns(input logic [15:0] len,
                                            input logic [2:0]  spd);
        logic [31:0] bits;
        bits = ({16'd0, len} + OVERHEAD_BYTES) << 3;
        case (spd)
            LS_10:   return bits * 32'd100;
            LS_100:  return bits * 32'd10;
            LS_2G5:  return (bits * 32'd2 + 32'd4) / 32'd5;
            default: return bits;
        endcase
    endfunction

endpackage

// File: rtl/tqg_phase.sv
module tqg_phase
    import tqg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            fut_dis,
    input  logic [SECW-1:0] now_sec,
    input  logic [NSW-1:0]  now_ns,
    input  logic [NSW-1:0]  cycle_ns,
    input  logic [SECW-1:0] base_sec_in,
    input  logic            base_sec_wr,
    input  logic [NSW-1:0]  base_ns_in,
    input  logic            base_ns_wr,
    output phase_t          ph
);
    logic            run_q, pend_q;
    logic [SECW-1:0] shadow_q, psec_q, prev_sec_q;
    logic [NSW-1:0]  pns_q, pos_q, prev_ns_q;

    logic            reach, run_now;
    logic [31:0]     step, inc, fresh;
    logic [NSW-1:0]  pos_now;

    always_comb begin
        reach   = pend_q && time_ge(now_sec, now_ns, psec_q, pns_q);
        run_now = run_q || reach;
        step    = ns_gap(now_sec, now_ns, prev_sec_q, prev_ns_q);
        inc     = {2'b00, pos_q} + step;
        if (inc >= {2'b00, cycle_ns})
            inc = inc - {2'b00, cycle_ns};
        fresh   = ns_gap(now_sec, now_ns, psec_q, pns_q);
        if (fresh >= {2'b00, cycle_ns})
            fresh = fresh - {2'b00, cycle_ns};
        if (reach)
            pos_now = fresh[NSW-1:0];
        else if (run_q)
            pos_now = inc[NSW-1:0];
        else
            pos_now = '0;
        ph = '{live: run_now, pos: pos_now};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            shadow_q   <= '0;
            psec_q     <= '0;
            pns_q      <= '0;
            pos_q      <= '0;
            prev_sec_q <= '0;
            prev_ns_q  <= '0;
        end else begin
            prev_sec_q <= now_sec;
            prev_ns_q  <= now_ns;
            if (base_sec_wr)
                shadow_q <= base_sec_in;
            if (!en) begin
                run_q  <= 1'b0;
                pend_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                run_q <= run_now;
                pos_q <= pos_now;
                if (reach)
                    pend_q <= 1'b0;
                if (base_ns_wr) begin
                    if (run_now || fut_dis) begin
                        pend_q <= 1'b1;
                        psec_q <= shadow_q;
                        pns_q  <= base_ns_in;
                    end else begin
                        run_q <= 1'b1;
                        pos_q <= '0;
                    end
                end
            end
        end
    end

    AST_POS_BELOW_CYCLE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> pos_q < cycle_ns);                                   // R3
    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && fut_dis && base_ns_wr && !run_now) |=> !run_q);          // R8
    AST_OLD_CYCLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (en && run_q) |=> run_q);                                      // R9

endmodule

// File: rtl/tqg_gate.sv
module tqg_gate
    import tqg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            strict_en,
    input  logic            lmode,
    input  logic            vld,
    input  logic [NSW-1:0]  w_start,
    input  logic [NSW-1:0]  w_end,
    input  logic [NSW-1:0]  cycle_ns,
    input  logic [2:0]      spd,
    input  logic [15:0]     len,
    input  logic [SECW-1:0] l_sec,
    input  logic [NSW-1:0]  l_ns,
    input  logic [SECW-1:0] now_sec,
    input  logic [NSW-1:0]  now_ns,
    input  logic [NSW-1:0]  ofs,
    input  phase_t          ph,
    output logic            ok
);
    logic [31:0]     dur, fin, adj_ns;
    logic [SECW-1:0] adj_sec;
    logic            open_all, gate, fit, lok;

    always_comb begin
        dur      = wire_ns(len, spd);
        fin      = {2'b00, ph.pos} + dur;
        open_all = (w_start == '0) && (w_end >= cycle_ns);
        if (ph.live)
            gate = (ph.pos >= w_start) && (ph.pos < w_end);
        else
            gate = open_all;
        fit = !(strict_en && ph.live) ||
              ((fin <= {2'b00, w_end}) && (fin <= {2'b00, cycle_ns}));
        adj_ns  = {2'b00, now_ns} + {2'b00, ofs};
        adj_sec = now_sec;
        if (adj_ns >= NS_PER_SEC) begin
            adj_ns  = adj_ns - NS_PER_SEC;
            adj_sec = now_sec + 1'b1;
        end
        lok = !lmode || time_ge(adj_sec, adj_ns[NSW-1:0], l_sec, l_ns);
        ok  = en ? (vld && gate && fit && lok) : vld;
    end

    AST_NO_HEAD_NO_GO: assert property (@(posedge clk) disable iff (rst)
        !vld |-> !ok);                                                  // R2
    AST_IDLE_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        (en && !ph.live && !((w_start == '0) && (w_end >= cycle_ns))) |-> !ok); // R8
    AST_STRICT_CYCLE_FIT: assert property (@(posedge clk) disable iff (rst)
        (en && strict_en && ph.live && ok) |-> ({2'b00, ph.pos} + dur <= {2'b00, cycle_ns})); // R5

endmodule

// File: rtl/txq_gate_sched.sv
module txq_gate_sched
    import tqg_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int LEN_W  = 14,
    parameter int OFS_10   = 600,
    parameter int OFS_100  = 200,
    parameter int OFS_1G   = 80,
    parameter int OFS_2G5  = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tsn_en,
    input  logic                strict_en,
    input  logic                sched_defer,
    input  logic [2:0]          link_spd,
    input  logic [31:0]         now_sec,
    input  logic [29:0]         now_ns,
    input  logic [29:0]         cycle_ns,
    input  logic [31:0]         base_sec,
    input  logic                base_sec_wr,
    input  logic [29:0]         base_ns,
    input  logic                base_ns_wr,
    input  logic [NQ*30-1:0]    win_start,
    input  logic [NQ*30-1:0]    win_end,
    input  logic [NQ-1:0]       launch_mode,
    input  logic [NQ-1:0]       head_vld,
    input  logic [NQ*LEN_W-1:0] head_len,
    input  logic [NQ*32-1:0]    launch_sec,
    input  logic [NQ*30-1:0]    launch_ns,
    output logic [NQ-1:0]       tx_ok
);
    phase_t         ph;
    logic [NSW-1:0] ofs;

    always_comb begin
        case (link_spd)
            LS_10:   ofs = NSW'(OFS_10);
            LS_100:  ofs = NSW'(OFS_100);
            LS_1G:   ofs = NSW'(OFS_1G);
            LS_2G5:  ofs = NSW'(OFS_2G5);
            default: ofs = '0;
        endcase
    end

    tqg_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .en          (tsn_en),
        .fut_dis     (sched_defer),
        .now_sec     (now_sec),
        .now_ns      (now_ns),
        .cycle_ns    (cycle_ns),
        .base_sec_in (base_sec),
        .base_sec_wr (base_sec_wr),
        .base_ns_in  (base_ns),
        .base_ns_wr  (base_ns_wr),
        .ph          (ph)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        tqg_gate u_gate (
            .clk       (clk),
            .rst       (rst),
            .en        (tsn_en),
            .strict_en (strict_en),
            .lmode     (launch_mode[q]),
            .vld       (head_vld[q]),
            .w_start   (win_start[q*30 +: 30]),
            .w_end     (win_end[q*30 +: 30]),
            .cycle_ns  (cycle_ns),
            .spd       (link_spd),
            .len       (16'(head_len[q*LEN_W +: LEN_W])),
            .l_sec     (launch_sec[q*32 +: 32]),
            .l_ns      (launch_ns[q*30 +: 30]),
            .now_sec   (now_sec),
            .now_ns    (now_ns),
            .ofs       (ofs),
            .ph        (ph),
            .ok        (tx_ok[q])
        );
    end

    AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !tsn_en |-> tx_ok == head_vld);                                 // R1

endmodule

// File: tb/txq_gate_sched_bench.sv
`timescale 1ns/1ps
module txq_gate_sched_bench;
    localparam int NQ = 4;
    localparam longint SEC = 64'd1000000000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        tsn_en = 0, strict_en = 0, sched_defer = 0;
    logic [2:0]  link_spd = 3'd2;
    logic [29:0] cycle_ns = 30'd1000000000;
    logic [31:0] base_sec = 0;
    logic        base_sec_wr = 0;
    logic [29:0] base_ns = 0;
    logic        base_ns_wr = 0;
    logic [NQ-1:0] launch_mode = 0, head_vld = 0;
    logic [29:0] ws [NQ];
    logic [29:0] we [NQ];
    logic [13:0] hl [NQ];
    logic [63:0] lt [NQ];
    logic [63:0] t;

    logic [NQ*30-1:0] win_start, win_end, launch_ns;
    logic [NQ*14-1:0] head_len;
    logic [NQ*32-1:0] launch_sec;
    logic [31:0] now_sec;
    logic [29:0] now_ns;
    logic [NQ-1:0] tx_ok;

    always_comb begin
        now_sec = 32'(t / SEC);
        now_ns  = 30'(t % SEC);
        for (int q = 0; q < NQ; q++) begin
            win_start[q*30 +: 30]  = ws[q];
            win_end[q*30 +: 30]    = we[q];
            head_len[q*14 +: 14]   = hl[q];
            launch_sec[q*32 +: 32] = 32'(lt[q] / SEC);
            launch_ns[q*30 +: 30]  = 30'(lt[q] % SEC);
        end
    end

    txq_gate_sched u_txq_gate_sched (
        .clk(clk), .rst(rst), .tsn_en(tsn_en), .strict_en(strict_en),
        .sched_defer(sched_defer), .link_spd(link_spd), .now_sec(now_sec),
        .now_ns(now_ns), .cycle_ns(cycle_ns), .base_sec(base_sec),
        .base_sec_wr(base_sec_wr), .base_ns(base_ns), .base_ns_wr(base_ns_wr),
        .win_start(win_start), .win_end(win_end), .launch_mode(launch_mode),
        .head_vld(head_vld), .head_len(head_len), .launch_sec(launch_sec),
        .launch_ns(launch_ns), .tx_ok(tx_ok)
    );

    // Bench model of schedule state
    logic        m_run = 0, m_pend = 0;
    logic [63:0] m_anchor = 0, m_pend_t = 0;
    logic [31:0] m_shadow = 0;
    int vectors = 0, fails = 0;
    bit done = 0;

    function automatic longint dur_of(input int len, input int spd);
        longint bits = longint'(len + 20) * 8;
        case (spd)
            0: return bits * 100;
            1: return bits * 10;
            3: return (bits * 4 + 9) / 10;
            default: return bits;
        endcase
    endfunction

    function automatic longint ofs_of(input int spd);
        case (spd)
            0: return 600;
            1: return 200;
            2: return 80;
            3: return 40;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_ok(input int q);
        logic reach, live, gate, fit, lok;
        logic [63:0] anc;
        longint p, d;
        if (!tsn_en) return head_vld[q];
        if (!head_vld[q]) return 1'b0;
        reach = m_pend && (t >= m_pend_t);
        live  = m_run || reach;
        anc   = reach ? m_pend_t : m_anchor;
        d     = dur_of(int'(hl[q]), int'(link_spd));
        fit   = 1'b1;
        if (!live) begin
            gate = (ws[q] == 0) && (we[q] >= cycle_ns);
        end else begin
            p    = longint'((t - anc) % 64'(cycle_ns));
            gate = (p >= longint'(ws[q])) && (p < longint'(we[q]));
            if (strict_en)
                fit = (p + d <= longint'(we[q])) && (p + d <= longint'(cycle_ns));
        end
        lok = !launch_mode[q] || (longint'(t) + ofs_of(int'(link_spd)) >= longint'(lt[q]));
        return gate && fit && lok;
    endfunction

    task automatic model_edge();
        logic reach;
        if (rst) begin
            m_run = 0; m_pend = 0; m_shadow = 0;
        end else begin
            if (!tsn_en) begin
                m_run = 0; m_pend = 0;
            end else begin
                reach = m_pend && (t >= m_pend_t);
                if (reach) begin
                    m_run = 1; m_anchor = m_pend_t; m_pend = 0;
                end
                if (base_ns_wr) begin
                    if (m_run || sched_defer) begin
                        m_pend = 1;
                        m_pend_t = 64'(m_shadow) * SEC + 64'(base_ns);
                    end else begin
                        m_run = 1; m_anchor = t;
                    end
                end
            end
            if (base_sec_wr) m_shadow = base_sec;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            #1;
            if (!done) begin
                for (int q = 0; q < NQ; q++) begin
                    logic e;
                    e = exp_ok(q);
                    vectors++;
                    if (tx_ok[q] !== e) begin
                        fails++;
                        $display("FAIL %s q%0d t=%0d tx_ok actual=%b expected=%b",
                                 tag, q, t, tx_ok[q], e);
                    end
                end
            end
            @(posedge clk);
            model_edge();
            @(negedge clk);
            t = t + 4;
            base_sec_wr = 0;
            base_ns_wr  = 0;
        end
    endtask

    // R10: seconds captured first, nanoseconds commit
    task automatic write_base(input logic [63:0] bt, input string tag);
        base_sec = 32'(bt / SEC); base_sec_wr = 1;
        run(1, tag);
        base_sec = 32'hdead; // later seconds value must not be used
        base_ns = 30'(bt % SEC); base_ns_wr = 1;
        run(1, tag);
    endtask

    task automatic rand_cfg();
        cycle_ns = 30'(500 + ($urandom % 376) * 4);
        for (int q = 0; q < NQ; q++) begin
            if ($urandom % 4 == 0) begin
                ws[q] = 0; we[q] = cycle_ns;
            end else begin
                ws[q] = 30'($urandom % cycle_ns);
                we[q] = ws[q] + 30'($urandom % (cycle_ns - ws[q])) + 1;
            end
            hl[q] = 14'($urandom % 120);
            lt[q] = t + 64'($urandom % 3000);
        end
        launch_mode = 4'($urandom);
        strict_en   = 1'($urandom);
        link_spd    = 3'($urandom % 6);
        if (link_spd == 0 || link_spd == 1) link_spd = 3'd2 + 3'($urandom % 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        t = 64'd3 * SEC - 64'd6000;
        for (int q = 0; q < NQ; q++) begin
            ws[q] = 0; we[q] = 30'd1000000000; hl[q] = 0; lt[q] = 0;
        end
        @(negedge clk);
        run(3, "reset");
        rst = 0;
        // Reset state: nothing queued, nothing eligible (R2)
        run(2, "R2");
        // Disabled: odd windows, launch far away, all must pass through (R1)
        head_vld = 4'b1011; launch_mode = 4'hF; strict_en = 1;
        ws[0] = 10; we[0] = 20; cycle_ns = 30'd100; lt[1] = t + 64'd900000;
        run(4, "R1");
        // Enabled, defaults: all windows always open (R8)
        tsn_en = 1; launch_mode = 0; strict_en = 0;
        cycle_ns = 30'd1000000000; ws[0] = 0; we[0] = 30'd1000000000;
        run(4, "R8");
        // Deferred base far ahead: only always-open queues pass (R8)
        sched_defer = 1; cycle_ns = 30'd1000; head_vld = 4'hF;
        ws[0] = 0; we[0] = 1000; ws[1] = 100; we[1] = 300;
        ws[2] = 0; we[2] = 999; ws[3] = 500; we[3] = 1000;
        write_base(t + 64'd2000, "R10");
        run(700, "R8");
        // Strict boundary at 2500 Mb/s, zero length -> 64 ns (R5, R6)
        strict_en = 1; link_spd = 3'd3;
        run(600, "R5");
        link_spd = 3'd5; hl[1] = 14'd5;
        run(300, "R6");
        link_spd = 3'd0; hl[1] = 14'd0;
        run(300, "R6");
        // Non-strict: crossing frames allowed (R4)
        strict_en = 0; link_spd = 3'd1; hl[1] = 14'd600;
        run(600, "R4");
        // Launch exact boundary at 1000 Mb/s, offset 80 (R7)
        launch_mode = 4'b0101; link_spd = 3'd2;
        lt[0] = t + 64'd200; lt[2] = t + 64'd404;
        run(150, "R7");
        link_spd = 3'd4; lt[0] = t + 64'd100; lt[2] = t + 64'd40;
        run(60, "R7");
        launch_mode = 0;
        // Reconfiguration while running (R9)
        write_base(t + 64'd1234, "R9");
        run(800, "R9");
        // Immediate start without deferral (R3)
        tsn_en = 0; run(2, "R1");
        tsn_en = 1; sched_defer = 0;
        write_base(t + 64'd50000, "R3");
        run(800, "R3");
        // Random segments
        for (int s = 0; s < 24; s++) begin
            tsn_en = 0; run(1, "R1");
            tsn_en = 1;
            rand_cfg();
            sched_defer = 1'($urandom);
            write_base(t + 64'($urandom % 1500) + 8, "R3");
            for (int k = 0; k < 6; k++) begin
                head_vld = 4'($urandom);
                for (int q = 0; q < NQ; q++) hl[q] = 14'($urandom % 120);
                run(60, "R4");
            end
            if ($urandom % 2 == 0) write_base(t + 64'($urandom % 800) + 100, "R9");
            run(400, "R9");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule